// File: doc/BRIEF.md
# USB Bus-Idle Duration Timer

This block measures how long a USB device has seen the bus in a sustained idle condition and reports, through registered flags, whether that idle stretch is still short, has passed roughly 3.0 ms, has passed roughly 3.125 ms, or has passed roughly 5.0 ms. A line-state manager uses these flags to tell a suspend request from a bus reset. The block runs on the 60 MHz transceiver clock and receives a single `idle_long` qualifier from the line-state sampling logic. It also receives a synchronous clear, so the manager can restart a measurement without leaving idle.

Time is built up in three cascaded stages. A fast prescaler divides the clock by 15 to form a 250 ns strobe. A middle stage divides that strobe by 250 to form a 62.5 us strobe. An 8-bit unit counter counts 62.5 us strobes, and all millisecond thresholds are compared against this unit counter. The unit counter stops advancing once the 5.0 ms limit has been passed, so it saturates and never wraps. Whenever idle ends or the clear is applied, every stage returns to zero, and each idle period is therefore measured from its first cycle.

Top module: `usb_idle_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every counter clears, both tick strobes are 0, `idle_lt_3ms` is 1 and the three "above" flags are 0.
- R2: While idle runs (`idle_long`=1, `idle_clr`=0), `tick_250ns` is a one-cycle pulse that is high after every PRE_DIV-th consecutive idle edge (edges PRE_DIV, 2*PRE_DIV, and so on), and low otherwise.
- R3: `tick_62us` is a one-cycle pulse that is high after every (PRE_DIV*MID_DIV)-th consecutive idle edge. It is always coincident with a `tick_250ns` pulse.
- R4: `idle_lt_3ms` is 1 exactly while the number of completed 62.5 us units is below TH_3MS (48).
- R5: `idle_gt_3ms` is 1 exactly while the completed unit count is strictly greater than TH_3MS. It first rises together with the 49th `tick_62us` pulse, which is within one unit of the nominal 3.0 ms.
- R6: `idle_gt_3p1ms` is 1 exactly while the unit count is strictly greater than TH_3P1MS (50).
- R7: `idle_gt_5ms` is 1 exactly while the unit count is strictly greater than TH_5MS (80). The unit count then holds at TH_5MS+1, so all flags stay unchanged for as long as idle continues, including past 256 units.
- R8: A clock edge with `idle_long`=0 zeroes all three stages. After that edge the ticks are 0, `idle_lt_3ms` is 1 and the "above" flags are 0.
- R9: A clock edge with `idle_clr`=1 has the same effect as R8 even while `idle_long`=1. The next measurement restarts from zero, so `idle_gt_3ms` rises again exactly (TH_3MS+1)*PRE_DIV*MID_DIV idle edges after the clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver clock, 60 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| idle_long | input | 1 | Bus has been seen in sustained idle |
| idle_clr | input | 1 | Synchronous restart of the measurement |
| tick_250ns | output | 1 | Registered strobe of the fast prescaler |
| tick_62us | output | 1 | Registered strobe of the middle stage |
| idle_lt_3ms | output | 1 | Idle time below 3.0 ms |
| idle_gt_3ms | output | 1 | Idle time above 3.0 ms |
| idle_gt_3p1ms | output | 1 | Idle time above 3.125 ms |
| idle_gt_5ms | output | 1 | Idle time above 5.0 ms |

## Verification
The assertions check, on every cycle, the orderings between the flags (above-5 implies above-3.125 implies above-3, and above-3 excludes below-3). They also check that a rising threshold flag coincides with a 62.5 us strobe, that strobes are single-cycle and nested, that a dropped idle or a clear empties everything on the next edge, and that the 5.0 ms flag holds while idle continues. Only the bench's scenarios can show the exact edge on which each flag first rises and that the saturated count does not wrap after hundreds of units. The same applies to restarting from zero after a clear. The bench confirms these against an elapsed-cycle model using shortened divider parameters.

// File: rtl/usb_idle_pkg.sv
package usb_idle_pkg;

  // Number of cascaded prescale stages ahead of the unit counter.
  localparam int NUM_PRESCALE = 2;

  // Registered threshold flags, grouped for internal transport.
  typedef struct packed {
    logic lt_3ms;
    logic gt_3ms;
    logic gt_3p1ms;
    logic gt_5ms;
  } idle_flags_t;

  localparam idle_flags_t FLAGS_CLEARED = '{lt_3ms: 1'b1, gt_3ms: 1'b0,
                                            gt_3p1ms: 1'b0, gt_5ms: 1'b0};

  // Width needed to hold values 0..n-1, never below one bit.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/idle_prescale_stage.sv
module idle_prescale_stage #(
  parameter int DIV = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic adv,
  output logic wrap,
  output logic tick_q
);
  import usb_idle_pkg::*;

  localparam int W = cnt_width(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  // Wrap is combinational so the next stage advances in the same cycle.
  assign wrap = run && adv && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= wrap;
  end

endmodule

// File: rtl/idle_unit_counter.sv
module idle_unit_counter #(
  parameter int CW        = 8,
  parameter int SAT_LIMIT = 80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          adv,
  output logic [CW-1:0] cnt_next
);
  logic [CW-1:0] cnt_q;
  logic          saturated;

  // Advancing stops once the count passes the top threshold.
  assign saturated = (cnt_q > CW'(SAT_LIMIT));

  always_comb begin
    if (!run)                  cnt_next = '0;
    else if (adv && !saturated) cnt_next = cnt_q + 1'b1;
    else                       cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

endmodule

// File: rtl/idle_threshold_flags.sv
module idle_threshold_flags
  import usb_idle_pkg::*;
#(
  parameter int CW       = 8,
  parameter int TH_3MS   = 48,
  parameter int TH_3P1MS = 50,
  parameter int TH_5MS   = 80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_next,
  output idle_flags_t   flags_q
);
  idle_flags_t flags_d;

  always_comb begin
    flags_d.lt_3ms   = (cnt_next <  CW'(TH_3MS));
    flags_d.gt_3ms   = (cnt_next >  CW'(TH_3MS));
    flags_d.gt_3p1ms = (cnt_next >  CW'(TH_3P1MS));
    flags_d.gt_5ms   = (cnt_next >  CW'(TH_5MS));
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= FLAGS_CLEARED;
    else     flags_q <= flags_d;
  end

endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int PRE_DIV  = 15,
  parameter int MID_DIV  = 250,
  parameter int MS_W     = 8,
  parameter int TH_3MS   = 48,
  parameter int TH_3P1MS = 50,
  parameter int TH_5MS   = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_long,
  input  logic idle_clr,
  output logic tick_250ns,
  output logic tick_62us,
  output logic idle_lt_3ms,
  output logic idle_gt_3ms,
  output logic idle_gt_3p1ms,
  output logic idle_gt_5ms
);
  import usb_idle_pkg::*;

  localparam int DIVS [NUM_PRESCALE] = '{PRE_DIV, MID_DIV};

  logic                    run;
  logic [NUM_PRESCALE:0]   adv_chain;
  logic [NUM_PRESCALE-1:0] ticks;
  logic [MS_W-1:0]         unit_next;
  idle_flags_t             flags;

  assign run          = idle_long && !idle_clr;
  assign adv_chain[0] = 1'b1;

  for (genvar g = 0; g < NUM_PRESCALE; g++) begin : g_stage
    idle_prescale_stage #(
      .DIV (DIVS[g])
    ) u_stage (
      .clk    (clk),
      .rst    (rst),
      .run    (run),
      .adv    (adv_chain[g]),
      .wrap   (adv_chain[g+1]),
      .tick_q (ticks[g])
    );
  end

  idle_unit_counter #(
    .CW        (MS_W),
    .SAT_LIMIT (TH_5MS)
  ) u_units (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .adv      (adv_chain[NUM_PRESCALE]),
    .cnt_next (unit_next)
  );

  idle_threshold_flags #(
    .CW       (MS_W),
    .TH_3MS   (TH_3MS),
    .TH_3P1MS (TH_3P1MS),
    .TH_5MS   (TH_5MS)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .cnt_next (unit_next),
    .flags_q  (flags)
  );

  assign tick_250ns    = ticks[0];
  assign tick_62us     = ticks[1];
  assign idle_lt_3ms   = flags.lt_3ms;
  assign idle_gt_3ms   = flags.gt_3ms;
  assign idle_gt_3p1ms = flags.gt_3p1ms;
  assign idle_gt_5ms   = flags.gt_5ms;

endmodule

// File: rtl/usb_idle_timer_chk.sv
module usb_idle_timer_chk (
  input logic clk,
  input logic rst,
  input logic idle_long,
  input logic idle_clr,
  input logic tick_250ns,
  input logic tick_62us,
  input logic idle_lt_3ms,
  input logic idle_gt_3ms,
  input logic idle_gt_3p1ms,
  input logic idle_gt_5ms
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (idle_lt_3ms && !idle_gt_3ms && !tick_250ns && !tick_62us));

  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_62us |=> !tick_62us);

  a_r3_nested_ticks: assert property (@(posedge clk) disable iff (rst)
    tick_62us |-> tick_250ns);

  a_r4_lt_excludes_gt: assert property (@(posedge clk) disable iff (rst)
    idle_gt_3ms |-> !idle_lt_3ms);

  a_r5_rise_on_unit: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_gt_3ms) |-> tick_62us);

  a_r6_order: assert property (@(posedge clk) disable iff (rst)
    idle_gt_3p1ms |-> idle_gt_3ms);

  a_r6_rise_on_unit: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_gt_3p1ms) |-> tick_62us);

  a_r7_order: assert property (@(posedge clk) disable iff (rst)
    idle_gt_5ms |-> idle_gt_3p1ms);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (idle_gt_5ms && idle_long && !idle_clr) |=> idle_gt_5ms);

  a_r8_idle_drop: assert property (@(posedge clk) disable iff (rst)
    !idle_long |=> (idle_lt_3ms && !idle_gt_3ms && !idle_gt_5ms &&
                    !tick_250ns && !tick_62us));

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    idle_clr |=> (idle_lt_3ms && !idle_gt_3ms && !idle_gt_5ms &&
                  !tick_250ns && !tick_62us));

endmodule

bind usb_idle_timer usb_idle_timer_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .idle_long     (idle_long),
  .idle_clr      (idle_clr),
  .tick_250ns    (tick_250ns),
  .tick_62us     (tick_62us),
  .idle_lt_3ms   (idle_lt_3ms),
  .idle_gt_3ms   (idle_gt_3ms),
  .idle_gt_3p1ms (idle_gt_3p1ms),
  .idle_gt_5ms   (idle_gt_5ms)
);

// File: tb/tb_usb_idle_timer.sv
module tb_usb_idle_timer;

  localparam int CLK_PERIOD = 10;
  localparam int P    = 3;
  localparam int M    = 4;
  localparam int UNIT = P * M;
  localparam int T3   = 48;
  localparam int T31  = 50;
  localparam int T5   = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_long = 1'b0;
  logic idle_clr = 1'b0;
  logic tick_250ns, tick_62us, idle_lt_3ms, idle_gt_3ms, idle_gt_3p1ms, idle_gt_5ms;

  int checks = 0;
  int failures = 0;
  int elapsed = 0;
  int cur = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_idle_timer #(
    .PRE_DIV (P), .MID_DIV (M), .MS_W (8),
    .TH_3MS (T3), .TH_3P1MS (T31), .TH_5MS (T5)
  ) dut (
    .clk (clk), .rst (rst), .idle_long (idle_long), .idle_clr (idle_clr),
    .tick_250ns (tick_250ns), .tick_62us (tick_62us),
    .idle_lt_3ms (idle_lt_3ms), .idle_gt_3ms (idle_gt_3ms),
    .idle_gt_3p1ms (idle_gt_3p1ms), .idle_gt_5ms (idle_gt_5ms)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Reference model: elapsed consecutive idle edges, compared every clock.
  always @(posedge clk) begin
    int units;
    if (rst || !idle_long || idle_clr) elapsed = 0;
    else elapsed = elapsed + 1;
    units = elapsed / UNIT;
    if (units > T5 + 1) units = T5 + 1;
    #2;
    check("R2 tick_250ns", tick_250ns, elapsed > 0 && elapsed % P == 0);
    check("R3 tick_62us", tick_62us, elapsed > 0 && elapsed % UNIT == 0);
    check("R4 idle_lt_3ms", idle_lt_3ms, units < T3);
    check("R5 idle_gt_3ms", idle_gt_3ms, units > T3);
    check("R6 idle_gt_3p1ms", idle_gt_3p1ms, units > T31);
    check("R7 idle_gt_5ms", idle_gt_5ms, units > T5);
  end

  task automatic go_to(input int target);
    repeat (target - cur) @(posedge clk);
    #3;
    cur = target;
  endtask

  task automatic start_idle();
    @(negedge clk);
    idle_long = 1'b1;
    idle_clr  = 1'b0;
    cur = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 lt", idle_lt_3ms, 1'b1);
    check("R1 gt3", idle_gt_3ms, 1'b0);
    check("R1 gt5", idle_gt_5ms, 1'b0);
    check("R1 tick", tick_250ns | tick_62us, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    start_idle();
    go_to(P);            check("R2 first fast tick", tick_250ns, 1'b1);
    go_to(P + 1);        check("R2 single cycle", tick_250ns, 1'b0);
    go_to(UNIT);         check("R3 first unit tick", tick_62us, 1'b1);
    go_to(T3*UNIT - 1);  check("R4 still below", idle_lt_3ms, 1'b1);
    go_to(T3*UNIT);      check("R4 leaves below", idle_lt_3ms, 1'b0);
                         check("R5 not yet above", idle_gt_3ms, 1'b0);
    go_to((T3+1)*UNIT - 1); check("R5 just before", idle_gt_3ms, 1'b0);
    go_to((T3+1)*UNIT);  check("R5 rises within one unit", idle_gt_3ms, 1'b1);
    go_to((T31+1)*UNIT - 1); check("R6 just before", idle_gt_3p1ms, 1'b0);
    go_to((T31+1)*UNIT); check("R6 rises", idle_gt_3p1ms, 1'b1);
    go_to((T5+1)*UNIT - 1); check("R7 just before", idle_gt_5ms, 1'b0);
    go_to((T5+1)*UNIT);  check("R7 rises", idle_gt_5ms, 1'b1);
    go_to(300*UNIT);     check("R7 saturated no wrap", idle_gt_5ms, 1'b1);
                         check("R7 lt stays low", idle_lt_3ms, 1'b0);

    // R8: idle ends
    @(negedge clk); idle_long = 1'b0;
    @(posedge clk); #3;
    check("R8 gt5 drops", idle_gt_5ms, 1'b0);
    check("R8 lt returns", idle_lt_3ms, 1'b1);
    check("R8 gt3 drops", idle_gt_3ms, 1'b0);

    // R8: drop mid-unit, then a fresh count starts from zero
    start_idle();
    go_to(5*UNIT + 1);
    @(negedge clk); idle_long = 1'b0;
    @(negedge clk); idle_long = 1'b1; cur = 0;
    go_to(UNIT - 1);     check("R8 restart no early unit", tick_62us, 1'b0);
    go_to(UNIT);         check("R8 restart unit", tick_62us, 1'b1);

    // R9: clear while idle stays high
    start_idle();
    go_to((T3+1)*UNIT + 5); check("R9 above before clear", idle_gt_3ms, 1'b1);
    @(negedge clk); idle_clr = 1'b1;
    @(posedge clk); #3;
    check("R9 clear drops gt3", idle_gt_3ms, 1'b0);
    check("R9 clear sets lt", idle_lt_3ms, 1'b1);
    @(negedge clk); idle_clr = 1'b0; cur = 0;
    go_to((T3+1)*UNIT - 1); check("R9 restart before", idle_gt_3ms, 1'b0);
    go_to((T3+1)*UNIT);  check("R9 restart rises", idle_gt_3ms, 1'b1);

    // R1: reset in the middle of idle
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #3;
    check("R1 mid-run reset", idle_gt_3ms, 1'b0);
    check("R1 mid-run lt", idle_lt_3ms, 1'b1);
    @(negedge clk); rst = 1'b0; idle_long = 1'b0;
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule